// File: doc/BRIEF.md
# Chained Watchpoint Comparator Pair

This block watches a processor bus (address, data and an 8-bit control bus) with two watchpoint units and raises a debug break request when an armed unit sees a match. Each unit has a value register and a mask register for each of the three fields. A set mask bit removes that bit from the comparison. A unit that is armed through its enable bit contributes to a single registered break request.

Unit 1 can also qualify unit 0 in two ways. The chain link is a flip-flop in unit 1. It loads unit 1's data-field result whenever unit 1's address and control fields match, and unit 0 can require it to be set. This lets unit 0 express "B after A". The range link is unit 1's raw match in the current cycle. Unit 0 can require it, which lets two units express "A and B in the same cycle", such as an address window combined with a data value.

Software programs the twelve configuration registers through a small write/read port. A read returns data one cycle after the address is presented.

Top module: `wpc_pair`

## Requirements
- R1: After a synchronous reset, `brk_req` is 0 and every configuration register reads 0.
- R2: `reg_addr[4]` must be 0. `reg_addr[3]` picks the unit and `reg_addr[2:0]` picks the register: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask. Read data for `reg_addr` appears on `reg_rdata` one cycle later. Writes to any other address change nothing, and such addresses read 0. The control value register stores bits [10:0] and the control mask register stores bits [7:0]. Other bits of both read 0.
- R3: The address and data fields each match when every bus bit equals its value bit or has its mask bit set to 1.
- R4: The control field matches when each bus bit [7:0] equals control value bit [7:0] or has control mask bit [7:0] set to 1.
- R5: Control value bit 8 is the enable bit and has no mask bit. A unit with bit 8 clear never causes a break, whatever the mask settings. `brk_req` is registered and reflects the bus sampled one clock earlier.
- R6: `brk_req` is the OR of the two units' enabled matches.
- R7: Unit 1's chain register loads unit 1's data-field result on each cycle in which unit 1's address and control fields both match, and holds its value otherwise. Each unit's chain register reads back at control value bit 11.
- R8: A write to a unit's control value register clears that unit's chain register.
- R9: When unit 0's control value bit 9 is set, unit 0 matches only while unit 1's chain register is 1.
- R10: When unit 0's control value bit 10 is set, unit 0 matches only in a cycle in which unit 1's full match is true. Unit 1's enable bit plays no part in this condition.
- R11: Unit 1 has no upstream unit. Its chain input and range input are 0, so setting bit 9 or bit 10 in unit 1 stops it from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Observed bus address |
| bus_data | input | DATA_W | Observed bus data |
| bus_ctrl | input | 8 | Observed bus control signals |
| reg_addr | input | 5 | Configuration register address |
| reg_wr | input | 1 | Configuration write strobe |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Configuration read data, one cycle after address |
| brk_req | output | 1 | Registered debug break request |

## Verification
The assertions check the following on every cycle:
- the chain register's load, hold and clear behaviour;
- the gating of a unit's match by its chain and range inputs;
- that the break request always follows an enabled match one clock later, and never appears without one;
- that writes to unmapped addresses leave the configuration untouched.

Other behaviour can only be shown by the bench's scenarios, because it depends on a particular setup:
- the encodings of the mask and field comparisons against chosen values;
- the sequential "B after A" ordering across two bus cycles;
- the requirement that range qualification happens in the same cycle rather than the previous one;
- the register map and readback widths;
- that unit 1 cannot be satisfied through its tied-off links.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int NUM_UNITS = 2;
  localparam int CTRL_W    = 8;
  localparam int REG_W     = 32;
  localparam int RADDR_W   = 5;
  localparam int SEL_W     = 3;
  localparam int CV_W      = 11;
  localparam int EN_BIT    = 8;
  localparam int CHN_BIT   = 9;
  localparam int RNG_BIT   = 10;
  localparam int CHQ_BIT   = 11;

  typedef enum logic [SEL_W-1:0] {
    SEL_AV = 3'd0,
    SEL_AM = 3'd1,
    SEL_DV = 3'd2,
    SEL_DM = 3'd3,
    SEL_CV = 3'd4,
    SEL_CM = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic [REG_W-1:0]  av;
    logic [REG_W-1:0]  am;
    logic [REG_W-1:0]  dv;
    logic [REG_W-1:0]  dm;
    logic [CV_W-1:0]   cv;
    logic [CTRL_W-1:0] cm;
  } unit_cfg_t;
endpackage

// File: rtl/wpc_mask_cmp.sv
module wpc_mask_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] msk,
  input  logic [W-1:0] bus,
  output logic         hit
);
  logic [W-1:0] bit_ok;

  always_comb begin
    bit_ok = ~(val ^ bus) | msk;
    hit    = &bit_ok;
  end
endmodule

// File: rtl/wpc_regs.sv
module wpc_regs
  import wpc_pkg::*;
#(
  parameter int NU = NUM_UNITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [RADDR_W-1:0]    reg_addr,
  input  logic                  reg_wr,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic [NU-1:0]         chain_q,
  output unit_cfg_t [NU-1:0]    cfg,
  output logic [NU-1:0]         cv_wr,
  output logic [REG_W-1:0]      reg_rdata
);
  localparam int UNIT_W = $clog2(NU);
  localparam int HI_LSB = SEL_W + UNIT_W;

  unit_cfg_t [NU-1:0] cfg_q;
  logic               addr_ok;
  logic [UNIT_W-1:0]  unit_idx;
  reg_sel_e           sel;
  logic [REG_W-1:0]   rd_mux;
  logic [REG_W-1:0]   rdata_q;

  always_comb begin
    addr_ok  = ((reg_addr >> HI_LSB) == '0);
    unit_idx = reg_addr[HI_LSB-1:SEL_W];
    sel      = reg_sel_e'(reg_addr[SEL_W-1:0]);
  end

  for (genvar g = 0; g < NU; g++) begin : g_wr
    assign cv_wr[g] = reg_wr && addr_ok && (unit_idx == UNIT_W'(g)) && (sel == SEL_CV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (reg_wr && addr_ok) begin
      for (int i = 0; i < NU; i++) begin
        if (unit_idx == UNIT_W'(i)) begin
          case (sel)
            SEL_AV:  cfg_q[i].av <= reg_wdata;
            SEL_AM:  cfg_q[i].am <= reg_wdata;
            SEL_DV:  cfg_q[i].dv <= reg_wdata;
            SEL_DM:  cfg_q[i].dm <= reg_wdata;
            SEL_CV:  cfg_q[i].cv <= reg_wdata[CV_W-1:0];
            SEL_CM:  cfg_q[i].cm <= reg_wdata[CTRL_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_ok) begin
      for (int i = 0; i < NU; i++) begin
        if (unit_idx == UNIT_W'(i)) begin
          case (sel)
            SEL_AV: rd_mux = cfg_q[i].av;
            SEL_AM: rd_mux = cfg_q[i].am;
            SEL_DV: rd_mux = cfg_q[i].dv;
            SEL_DM: rd_mux = cfg_q[i].dm;
            SEL_CV: begin
              rd_mux[CV_W-1:0] = cfg_q[i].cv;
              rd_mux[CHQ_BIT]  = chain_q[i];
            end
            SEL_CM: rd_mux[CTRL_W-1:0] = cfg_q[i].cm;
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign cfg       = cfg_q;
  assign reg_rdata = rdata_q;

  // R2: an unmapped address never alters configuration
  assert_bad_addr_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !addr_ok) |=> $stable(cfg_q));

  // R1: read data is zero in the first cycle after reset
  assert_rdata_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_rdata == '0));
endmodule

// File: rtl/wpc_unit.sv
module wpc_unit
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [CTRL_W-1:0] bus_ctrl,
  input  unit_cfg_t         cfg,
  input  logic              cv_wr,
  input  logic              chain_in,
  input  logic              range_in,
  output logic              match,
  output logic              armed,
  output logic              chain_q
);
  logic a_hit, d_hit, c_hit, ac_hit;
  logic chain_ok, range_ok;
  logic chain_r;

  wpc_mask_cmp #(.W(ADDR_W)) u_acmp (
    .val(cfg.av[ADDR_W-1:0]), .msk(cfg.am[ADDR_W-1:0]), .bus(bus_addr), .hit(a_hit)
  );
  wpc_mask_cmp #(.W(DATA_W)) u_dcmp (
    .val(cfg.dv[DATA_W-1:0]), .msk(cfg.dm[DATA_W-1:0]), .bus(bus_data), .hit(d_hit)
  );
  wpc_mask_cmp #(.W(CTRL_W)) u_ccmp (
    .val(cfg.cv[CTRL_W-1:0]), .msk(cfg.cm), .bus(bus_ctrl), .hit(c_hit)
  );

  always_comb begin
    ac_hit   = a_hit & c_hit;
    chain_ok = ~cfg.cv[CHN_BIT] | chain_in;
    range_ok = ~cfg.cv[RNG_BIT] | range_in;
    match    = ac_hit & d_hit & chain_ok & range_ok;
    armed    = cfg.cv[EN_BIT];
  end

  // chain register: address/control hit is the load enable, data hit the value
  always_ff @(posedge clk) begin
    if (rst || cv_wr)  chain_r <= 1'b0;
    else if (ac_hit)   chain_r <= d_hit;
  end

  assign chain_q = chain_r;

  // R7: load on address/control hit
  assert_chain_load_R7: assert property (@(posedge clk) disable iff (rst)
    (ac_hit && !cv_wr) |=> (chain_q == $past(d_hit)));
  // R7: hold otherwise
  assert_chain_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ac_hit && !cv_wr) |=> $stable(chain_q));
  // R8: control value write clears chain
  assert_chain_clear_R8: assert property (@(posedge clk) disable iff (rst)
    cv_wr |=> !chain_q);
  // R9: chain qualification gates the match
  assert_chain_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg.cv[CHN_BIT] && !chain_in) |-> !match);
  // R10: range qualification gates the match
  assert_range_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg.cv[RNG_BIT] && !range_in) |-> !match);
endmodule

// File: rtl/wpc_pair.sv
module wpc_pair
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic [CTRL_W-1:0]  bus_ctrl,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               brk_req
);
  localparam int NU = NUM_UNITS;

  unit_cfg_t [NU-1:0] cfg;
  logic [NU-1:0] cv_wr;
  logic [NU-1:0] match, armed, chain_q;
  logic [NU-1:0] chain_link, range_link;
  logic          any_hit;
  logic          brk_q;

  wpc_regs #(.NU(NU)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .chain_q(chain_q), .cfg(cfg), .cv_wr(cv_wr), .reg_rdata(reg_rdata)
  );

  for (genvar g = 0; g < NU; g++) begin : g_unit
    if (g < NU - 1) begin : g_fed
      assign chain_link[g] = chain_q[g+1];
      assign range_link[g] = match[g+1];
    end else begin : g_head
      assign chain_link[g] = 1'b0;
      assign range_link[g] = 1'b0;
    end

    wpc_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wp (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
      .cfg(cfg[g]), .cv_wr(cv_wr[g]), .chain_in(chain_link[g]), .range_in(range_link[g]),
      .match(match[g]), .armed(armed[g]), .chain_q(chain_q[g])
    );
  end

  assign any_hit = |(match & armed);

  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= any_hit;
  end

  assign brk_req = brk_q;

  // R5: no break without an armed match one cycle earlier
  assert_brk_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(|(match & armed)));
  // R6: any armed unit match raises the break next cycle
  assert_brk_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (|(match & armed)) |=> brk_req);
  // R1: break low right after reset
  assert_brk_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !brk_req);
endmodule

// File: tb/sim_wpc_pair.sv
module sim_wpc_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic [7:0]  bus_ctrl = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        brk_req;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  wpc_pair u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .brk_req(brk_req)
  );

  // {addr, data, ctrl, expected break}; unit 0 set up for R3/R4 table
  localparam logic [72:0] VEC [10] = '{
    {32'h0000_1000, 32'hCAFE_1234, 8'h05, 1'b1},
    {32'h0000_10FF, 32'hCAFE_0000, 8'hA5, 1'b1},
    {32'h0000_1100, 32'hCAFE_0000, 8'h05, 1'b0},
    {32'h0000_1000, 32'hCAFF_0000, 8'h05, 1'b0},
    {32'h0000_1000, 32'hCAFE_0000, 8'h04, 1'b0},
    {32'h0000_9000, 32'hCAFE_0000, 8'h05, 1'b0},
    {32'h0000_1080, 32'hCAFE_FFFF, 8'hF5, 1'b1},
    {32'h0000_1000, 32'hCAFE_0000, 8'h15, 1'b1},
    {32'h0000_1000, 32'hCAFE_0000, 8'h0D, 1'b0},
    {32'h0000_1000, 32'h4AFE_0000, 8'h05, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_addr = 32'hF000_0000;
    bus_data = '0;
    bus_ctrl = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    idle();
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [4:0] a, input logic [31:0] exp);
    idle();
    reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [31:0] d,
                       input logic [7:0] c, input logic exp);
    bus_addr = a;
    bus_data = d;
    bus_ctrl = c;
    @(negedge clk);
    check(tag, {31'b0, brk_req}, {31'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 brk after reset", {31'b0, brk_req}, 32'h0);
    rd_check("R1 u0 addr value", 5'd0, 32'h0);
    rd_check("R1 u0 ctrl value", 5'd4, 32'h0);
    rd_check("R1 u1 ctrl mask", 5'd13, 32'h0);

    // R2 register map
    wr(5'd4, 32'hFFFF_FFFF);
    rd_check("R2 ctrl value width", 5'd4, 32'h0000_07FF);
    wr(5'd4, 32'h0);
    wr(5'd13, 32'hFFFF_FFFF);
    rd_check("R2 ctrl mask width", 5'd13, 32'h0000_00FF);
    wr(5'd6, 32'h1234_5678);
    rd_check("R2 unused slot", 5'd6, 32'h0);
    wr(5'd20, 32'h0000_01FF);
    rd_check("R2 high addr write ignored", 5'd4, 32'h0);
    rd_check("R2 high addr reads zero", 5'd20, 32'h0);
    wr(5'd0, 32'hDEAD_BEEF);
    rd_check("R2 addr value readback", 5'd0, 32'hDEAD_BEEF);

    // R3/R4 table on unit 0
    wr(5'd0, 32'h0000_1000);
    wr(5'd1, 32'h0000_00FF);
    wr(5'd2, 32'hCAFE_0000);
    wr(5'd3, 32'h0000_FFFF);
    wr(5'd5, 32'h0000_00F0);
    wr(5'd4, 32'h0000_0105);
    for (int i = 0; i < 10; i++) begin
      probe($sformatf("R3/R4 vector %0d", i), VEC[i][72:41], VEC[i][40:9], VEC[i][8:1], VEC[i][0]);
    end

    // R5 enable gates and cannot be masked
    wr(5'd4, 32'h0000_0005);
    probe("R5 enable clear", 32'h1000, 32'hCAFE_0000, 8'h05, 1'b0);
    wr(5'd5, 32'hFFFF_FFFF);
    probe("R5 full mask no enable", 32'h1000, 32'hCAFE_0000, 8'h05, 1'b0);
    wr(5'd5, 32'h0000_00F0);
    wr(5'd4, 32'h0000_0105);
    probe("R5 enable restored", 32'h1000, 32'hCAFE_0000, 8'h05, 1'b1);

    // R6 OR of units
    wr(5'd8, 32'h0000_2000);
    wr(5'd9, 32'h0);
    wr(5'd11, 32'hFFFF_FFFF);
    wr(5'd13, 32'h0000_00FF);
    wr(5'd12, 32'h0000_0100);
    probe("R6 unit1 alone", 32'h2000, 32'h0, 8'h00, 1'b1);
    probe("R6 unit0 alone", 32'h1000, 32'hCAFE_0000, 8'h05, 1'b1);
    probe("R6 neither", 32'h3000, 32'h0, 8'h00, 1'b0);

    // R7/R8/R9 chain link
    wr(5'd0, 32'h0000_1000);
    wr(5'd1, 32'h0);
    wr(5'd3, 32'hFFFF_FFFF);
    wr(5'd5, 32'h0000_00FF);
    wr(5'd4, 32'h0000_0300);
    wr(5'd10, 32'h0000_0055);
    wr(5'd11, 32'h0);
    wr(5'd12, 32'h0);
    probe("R9 no chain yet", 32'h1000, 32'h0, 8'h00, 1'b0);
    probe("R7 arm chain", 32'h2000, 32'h55, 8'h00, 1'b0);
    rd_check("R7 chain set readback", 5'd12, 32'h0000_0800);
    probe("R9 chained match", 32'h1000, 32'h0, 8'h00, 1'b1);
    rd_check("R7 unit0 chain readback", 5'd4, 32'h0000_0B00);
    probe("R7 no load", 32'h3000, 32'h54, 8'h00, 1'b0);
    rd_check("R7 chain held", 5'd12, 32'h0000_0800);
    probe("R7 load zero", 32'h2000, 32'h54, 8'h00, 1'b0);
    rd_check("R7 chain cleared by data miss", 5'd12, 32'h0);
    probe("R9 chain lost", 32'h1000, 32'h0, 8'h00, 1'b0);
    probe("R8 re-arm", 32'h2000, 32'h55, 8'h00, 1'b0);
    wr(5'd12, 32'h0);
    rd_check("R8 chain cleared by write", 5'd12, 32'h0);
    probe("R8 no chained match", 32'h1000, 32'h0, 8'h00, 1'b0);

    // R10 range link
    wr(5'd1, 32'h0000_0FFF);
    wr(5'd4, 32'h0000_0500);
    wr(5'd8, 32'h0);
    wr(5'd9, 32'hFFFF_FFFF);
    wr(5'd10, 32'h0000_0055);
    wr(5'd11, 32'h0);
    wr(5'd13, 32'h0000_00FF);
    wr(5'd12, 32'h0);
    probe("R10 both true", 32'h1234, 32'h55, 8'h00, 1'b1);
    probe("R10 unit1 false", 32'h1234, 32'h56, 8'h00, 1'b0);
    probe("R10 unit0 false", 32'h2234, 32'h55, 8'h00, 1'b0);
    probe("R10 prior cycle", 32'h5000, 32'h55, 8'h00, 1'b0);
    probe("R10 not same cycle", 32'h1234, 32'h56, 8'h00, 1'b0);

    // R11 unit 1 has no upstream
    wr(5'd12, 32'h0000_0300);
    probe("R11 chain bit in unit1", 32'h7777, 32'h55, 8'h00, 1'b0);
    wr(5'd12, 32'h0000_0500);
    probe("R11 range bit in unit1", 32'h7777, 32'h55, 8'h00, 1'b0);
    wr(5'd12, 32'h0000_0100);
    probe("R11 plain enable", 32'h7777, 32'h55, 8'h00, 1'b1);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule